// File: doc/BRIEF.md
# Half-Bridge Gate Enable Controller

This block turns a pulse-width command and a small set of control inputs into the two gate enables of a half-bridge, one for the high-side switch and one for the low-side switch. A mode input selects how the command is used. In synchronous mode the command drives both switches in a complementary way. An interlock state machine sits between the command and the gates. Before it enables a gate, it waits until the other switch reports, through a digital gate-off feedback flag, that it is off, and that flag has stayed asserted for a programmable dead time. In independent mode the command drives only the high side and a separate low-side command input drives the low side directly. No interlock acts in that mode, so the source of the inputs is responsible for avoiding overlap.

A separate detector supplies a flag that marks a floating command line. While that flag is set, both gates are forced off in either mode. The forcing path is combinational, so the gates drop in the same cycle the flag rises. Leaving synchronous mode, or raising the floating flag, returns the interlock to its idle state. Every later turn-on in synchronous mode therefore goes through the full wait again.

Top module: `hb_gate_ctrl`

## Requirements
- R1: In synchronous mode (sync_mode = 1) with pwm_cmd = 1, once the interlock has finished waiting, hs_gate = 1 and ls_gate = 0.
- R2: In synchronous mode with pwm_cmd = 0, once the interlock has finished waiting, hs_gate = 0 and ls_gate = 1.
- R3: In synchronous mode a gate is enabled only after the feedback flag of the opposite switch (ls_is_off for a high-side turn-on, hs_is_off for a low-side turn-on) has been sampled high on DEAD_CYCLES consecutive rising edges since the wait began. The gate rises on the last of those edges. An edge that samples the flag low restarts the count.
- R4: In independent mode (sync_mode = 0) hs_gate equals pwm_cmd in the same cycle.
- R5: In independent mode ls_gate equals ls_direct in the same cycle.
- R6: In independent mode the feedback flags have no effect, and both gates may be high at the same time.
- R7: While float_det = 1, hs_gate = 0 and ls_gate = 0 in either mode, starting in the same cycle.
- R8: In synchronous mode ls_direct has no effect on either gate.
- R9: While rst = 1, and on the first edge after it, both gates are 0. The first synchronous turn-on after reset goes through the full wait.
- R10: A rising edge that samples sync_mode = 0 or float_det = 1 returns the interlock to idle. The next synchronous turn-on then waits the full dead time.
- R11: If pwm_cmd reverses while a wait is running, the wait is abandoned and a fresh full wait toward the opposite gate starts on that edge.
- R12: In synchronous mode hs_gate and ls_gate are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1 selects synchronous (interlocked) mode, 0 selects independent mode |
| pwm_cmd | input | 1 | Pulse-width command, 1 requests the high-side switch |
| ls_direct | input | 1 | Direct low-side command, used only in independent mode |
| float_det | input | 1 | Floating-command indication from an external detector |
| hs_is_off | input | 1 | Synchronized flag: high-side switch confirmed off |
| ls_is_off | input | 1 | Synchronized flag: low-side switch confirmed off |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The floating-command override and the interlock can act in the same cycle. This happens when float_det rises while a gate is on or while a dead-time wait is running, and also when it falls while pwm_cmd is already requesting a switch. The bench raises the flag during a synchronous on-phase and checks that both gates drop without waiting for an edge. It then clears the flag and checks that the interlock restarts from idle, with both gates low for exactly DEAD_CYCLES edges before the requested gate rises. Mode changes in mid-sequence are judged the same way: the gates must follow the direct inputs at once, and the wait must be repeated in full when synchronous mode is selected again.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [2:0] {
        IL_IDLE    = 3'd0,
        IL_WAIT_HI = 3'd1,
        IL_HI_ON   = 3'd2,
        IL_WAIT_LO = 3'd3,
        IL_LO_ON   = 3'd4
    } il_state_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    localparam gate_pair_t GATES_OFF = '{hi: 1'b0, lo: 1'b0};

    function automatic gate_pair_t gates_of_state(input il_state_t st);
        gate_pair_t g;
        g    = GATES_OFF;
        g.hi = (st == IL_HI_ON);
        g.lo = (st == IL_LO_ON);
        return g;
    endfunction

    function automatic logic is_wait_state(input il_state_t st);
        return (st == IL_WAIT_HI) || (st == IL_WAIT_LO);
    endfunction

endpackage

// File: rtl/hb_dead_timer.sv
module hb_dead_timer #(
    parameter int DEAD_CYCLES = 4,
    localparam int CNT_W = $clog2(DEAD_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic flag,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEAD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    assign done = flag && (cnt_q == LAST);

    always_comb begin
        if (clear || !flag) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3: the count never passes its last value
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R3: a low flag sample restarts the count
    assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (rst)
        !flag |=> cnt_q == '0);

endmodule

// File: rtl/hb_interlock_fsm.sv
module hb_interlock_fsm
    import hb_gate_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       pwm_cmd,
    input  logic       hs_is_off,
    input  logic       ls_is_off,
    output gate_pair_t fsm_gates
);
    il_state_t state_q;
    il_state_t state_d;
    logic      wait_flag;
    logic      wait_done;
    logic      timer_clear;

    // the wait toward the high side watches the low-side flag and vice versa
    assign wait_flag   = (state_q == IL_WAIT_HI) ? ls_is_off : hs_is_off;
    assign timer_clear = !is_wait_state(state_q) || (state_d != state_q);

    hb_dead_timer #(
        .DEAD_CYCLES(DEAD_CYCLES)
    ) u_dead_timer (
        .clk  (clk),
        .rst  (rst),
        .clear(timer_clear),
        .flag (wait_flag),
        .done (wait_done)
    );

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = IL_IDLE;
        end else begin
            unique case (state_q)
                IL_IDLE:    state_d = pwm_cmd ? IL_WAIT_HI : IL_WAIT_LO;
                IL_WAIT_HI: begin
                    if (!pwm_cmd)       state_d = IL_WAIT_LO;
                    else if (wait_done) state_d = IL_HI_ON;
                end
                IL_HI_ON:   if (!pwm_cmd) state_d = IL_WAIT_LO;
                IL_WAIT_LO: begin
                    if (pwm_cmd)        state_d = IL_WAIT_HI;
                    else if (wait_done) state_d = IL_LO_ON;
                end
                IL_LO_ON:   if (pwm_cmd) state_d = IL_WAIT_HI;
                default:    state_d = IL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign fsm_gates = gates_of_state(state_q);

    // R3: high side enters its on state only after the low-side flag was seen
    assert_hi_needs_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == IL_HI_ON && $past(state_q) != IL_HI_ON) |-> $past(ls_is_off));

    // R3: low side enters its on state only after the high-side flag was seen
    assert_lo_needs_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == IL_LO_ON && $past(state_q) != IL_LO_ON) |-> $past(hs_is_off));

    // R3: an on state is reached only from the matching wait state
    assert_hi_from_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == IL_HI_ON && $past(state_q) != IL_HI_ON) |-> $past(state_q) == IL_WAIT_HI);

    // R10: leaving synchronous operation returns to idle
    assert_idle_on_stop_R10: assert property (@(posedge clk) disable iff (rst)
        !run |=> state_q == IL_IDLE);

    // R11: a command reversal during a wait heads for the other gate
    assert_reversal_R11: assert property (@(posedge clk) disable iff (rst)
        (run && state_q == IL_WAIT_HI && !pwm_cmd) |=> state_q == IL_WAIT_LO);

endmodule

// File: rtl/hb_out_select.sv
module hb_out_select
    import hb_gate_pkg::*;
(
    input  logic       sync_mode,
    input  logic       float_det,
    input  logic       pwm_cmd,
    input  logic       ls_direct,
    input  gate_pair_t fsm_gates,
    output gate_pair_t out_gates
);
    gate_pair_t direct_gates;

    always_comb begin
        direct_gates    = GATES_OFF;
        direct_gates.hi = pwm_cmd;
        direct_gates.lo = ls_direct;
    end

    always_comb begin
        if (float_det) begin
            out_gates = GATES_OFF;
        end else if (sync_mode) begin
            out_gates = fsm_gates;
        end else begin
            out_gates = direct_gates;
        end
    end

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_gate_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_mode,
    input  logic pwm_cmd,
    input  logic ls_direct,
    input  logic float_det,
    input  logic hs_is_off,
    input  logic ls_is_off,
    output logic hs_gate,
    output logic ls_gate
);
    gate_pair_t fsm_gates;
    gate_pair_t out_gates;
    logic       il_run;

    assign il_run = sync_mode && !float_det;

    hb_interlock_fsm #(
        .DEAD_CYCLES(DEAD_CYCLES)
    ) u_interlock (
        .clk      (clk),
        .rst      (rst),
        .run      (il_run),
        .pwm_cmd  (pwm_cmd),
        .hs_is_off(hs_is_off),
        .ls_is_off(ls_is_off),
        .fsm_gates(fsm_gates)
    );

    hb_out_select u_out_select (
        .sync_mode(sync_mode),
        .float_det(float_det),
        .pwm_cmd  (pwm_cmd),
        .ls_direct(ls_direct),
        .fsm_gates(fsm_gates),
        .out_gates(out_gates)
    );

    assign hs_gate = out_gates.hi;
    assign ls_gate = out_gates.lo;

    // R12: never both gates on in synchronous mode
    assert_sync_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        sync_mode |-> !(hs_gate && ls_gate));

    // R7: floating command forces both gates off
    assert_float_off_R7: assert property (@(posedge clk) disable iff (rst)
        float_det |-> (!hs_gate && !ls_gate));

    // R9: first edge after reset leaves both gates off
    assert_reset_off_R9: assert property (@(posedge clk)
        rst |=> (!hs_gate && !ls_gate) || !sync_mode);

endmodule

// File: tb/hb_gate_ctrl_bench.sv
module hb_gate_ctrl_bench;

    localparam int DEAD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_mode = 1'b0;
    logic pwm_cmd = 1'b0;
    logic ls_direct = 1'b0;
    logic float_det = 1'b0;
    logic hs_is_off = 1'b0;
    logic ls_is_off = 1'b0;
    logic hs_gate;
    logic ls_gate;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hb_gate_ctrl #(.DEAD_CYCLES(DEAD)) u_hb_gate_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sync_mode(sync_mode),
        .pwm_cmd  (pwm_cmd),
        .ls_direct(ls_direct),
        .float_det(float_det),
        .hs_is_off(hs_is_off),
        .ls_is_off(ls_is_off),
        .hs_gate  (hs_gate),
        .ls_gate  (ls_gate)
    );

    typedef struct packed {
        logic       sm;
        logic       pw;
        logic       ld;
        logic       fl;
        logic       hoff;
        logic       loff;
        logic [3:0] edges;
        logic       ehs;
        logic       els;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,4'd1,1'b1,1'b0,4'd4},   // R4
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,4'd1,1'b0,1'b1,4'd5},   // R5
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,1'b1,1'b1,4'd6},   // R6
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,4'd1,1'b0,1'b0,4'd7},   // R7
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd3,1'b0,1'b0,4'd3},   // R3 wait, R8
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd1,1'b0,1'b0,4'd3},   // R3
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd1,1'b1,1'b0,4'd1},   // R1
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,4'd3,1'b0,1'b0,4'd3},   // R3 no hs flag
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'd3,1'b0,1'b0,4'd3},   // R3
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'd1,1'b0,1'b1,4'd2},   // R2
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,4'd1,1'b0,1'b0,4'd7},   // R7 sync
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,4'd4,1'b0,1'b0,4'd10},  // R10
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,4'd1,1'b0,1'b1,4'd10},  // R10
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd2,1'b0,1'b0,4'd3},   // R3 restart
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'd1,1'b0,1'b0,4'd3},   // R3
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd3,1'b0,1'b0,4'd3},   // R3
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd1,1'b1,1'b0,4'd3},   // R3
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,4'd2,1'b0,1'b0,4'd11},  // R11
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd1,1'b0,1'b0,4'd11},  // R11
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd3,1'b0,1'b0,4'd11},  // R11
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd1,1'b1,1'b0,4'd11},  // R11
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,4'd1,1'b0,1'b1,4'd5},   // R5 mode exit
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd1,1'b0,1'b0,4'd10},  // R10 re-entry
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd3,1'b0,1'b0,4'd10},  // R10
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd1,1'b1,1'b0,4'd10},  // R10
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd2,1'b1,1'b0,4'd8},   // R8 ls_direct low
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd2,1'b1,1'b1,4'd6},   // R6 flags ignored
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd1,1'b0,1'b0,4'd4},   // R4
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'd4,1'b0,1'b0,4'd3},   // R3
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'd1,1'b0,1'b1,4'd2},   // R2
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3,1'b0,1'b1,4'd2},   // R2 holds
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'd5,1'b0,1'b0,4'd3},   // R3 ls flag low
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd4,1'b1,1'b0,4'd1}    // R1
    };

    task automatic check(input logic ehs, input logic els, input int req);
        n_run++;
        if (hs_gate !== ehs || ls_gate !== els) begin
            n_fail++;
            $display("FAIL R%0d: hs_gate/ls_gate = %b%b, expected %b%b",
                     req, hs_gate, ls_gate, ehs, els);
        end
        if (sync_mode && hs_gate && ls_gate) begin
            n_fail++;
            $display("FAIL R12: both gates high in synchronous mode, expected at most one");
        end
    endtask

    task automatic apply(input vec_t v);
        sync_mode = v.sm;
        pwm_cmd   = v.pw;
        ls_direct = v.ld;
        float_det = v.fl;
        hs_is_off = v.hoff;
        ls_is_off = v.loff;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R9: reset holds gates off even with a synchronous request pending
        sync_mode = 1'b1; pwm_cmd = 1'b1; hs_is_off = 1'b1; ls_is_off = 1'b1;
        repeat (3) @(negedge clk);
        check(1'b0, 1'b0, 9);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            repeat (int'(TBL[i].edges)) @(negedge clk);
            check(TBL[i].ehs, TBL[i].els, int'(TBL[i].req));
        end

        // R7: floating flag drops an active gate without waiting for an edge
        float_det = 1'b1;
        #1;
        check(1'b0, 1'b0, 7);
        @(negedge clk);
        float_det = 1'b0;
        #1;
        check(1'b0, 1'b0, 10);
        repeat (DEAD) @(negedge clk);
        check(1'b0, 1'b0, 10);
        @(negedge clk);
        check(1'b1, 1'b0, 1);

        // R9: mid-run reset clears the on state; the next turn-on waits in full
        rst = 1'b1;
        @(negedge clk);
        check(1'b0, 1'b0, 9);
        rst = 1'b0;
        repeat (DEAD) @(negedge clk);
        check(1'b0, 1'b0, 9);
        @(negedge clk);
        check(1'b1, 1'b0, 9);

        // R4: independent high side follows pwm_cmd within the cycle
        sync_mode = 1'b0; ls_direct = 1'b0; pwm_cmd = 1'b0;
        #1;
        check(1'b0, 1'b0, 4);
        pwm_cmd = 1'b1;
        #1;
        check(1'b1, 1'b0, 4);

        @(negedge clk);
        finish_run();
    end

endmodule